// File: doc/BRIEF.md
# Keyed Watchdog Timer with Cause Flags

This block is the watchdog of a small microcontroller core. It counts ticks from one of three selectable clock-enable sources, divides them by a power-of-two prescaler and then by a fixed-width overflow counter. When that counter wraps, the block issues a one-cycle request. The request is a reset while the core runs and a wake while it sleeps. The core must keep the count from running out by issuing the clear-watchdog strobe.

A 4-bit key register turns the block off or on, and a configuration input can force it on. Two status flags let software tell why it restarted. The power-down flag records that a halt was executed. The time-out flag records that the counter overflowed. A wake caused by an overflow changes only the time-out flag, so software can tell a sleep wake from a run-time reset.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the key register holds 4'b1010, the prescaler select holds 3'b111, and `wdt_on`, `pdf_flag`, `to_flag` and both request outputs are 0. The watchdog is off exactly when the key holds 4'b1010 and `cfg_wdt_force` is 0.
- R2: Writing any key value other than 4'b1010 turns the watchdog on. Holding `cfg_wdt_force` high turns it on whatever the key holds.
- R3: With select value S on `div_wdata`, the prescaler passes one tick in 2^S, from 1:1 up to 1:128 for S = 3'b111. A request appears 2^S * 2^CNT_W source ticks after a clear.
- R4: `cfg_src` picks the tick source: 2'b00 uses `xtal_tick`, 2'b01 uses the system clock divided by 4, and 2'b10 or 2'b11 use `rc_tick`. Sources that are not selected have no effect.
- R5: With the divided system clock selected, the watchdog does not advance while `sleeping` is high.
- R6: `halt` sets `pdf_flag`, and an effective clear resets it to 0. When both arrive in the same cycle, `halt` wins.
- R7: An overflow sets `to_flag`, and an effective clear resets it to 0.
- R8: An overflow while `sleeping` is high raises `wdt_wake_req` and not `wdt_reset_req`. Otherwise it raises `wdt_reset_req`. An overflow leaves `pdf_flag` unchanged.
- R9: While the watchdog is off, `clr_wdt` has no effect on either flag.
- R10: An effective clear returns the prescaler and the counter to zero, so the timing restarts from the clear.
- R11: Each request lasts one cycle. The counter restarts from zero, so the next request comes a full period later.
- R12: While the watchdog is off, the prescaler and the counter are held at zero. After it is turned on, the first request comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| cfg_wdt_force | input | 1 | Configuration: force watchdog on |
| cfg_src | input | 2 | Configuration: tick source select |
| xtal_tick | input | 1 | Low-speed crystal tick enable |
| rc_tick | input | 1 | Low-speed internal RC tick enable |
| sleeping | input | 1 | Core is in sleep or idle |
| key_we | input | 1 | Key register write strobe |
| key_wdata | input | 4 | Key register write data |
| div_we | input | 1 | Prescaler select write strobe |
| div_wdata | input | 3 | Prescaler select write data |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| halt | input | 1 | Halt strobe |
| wdt_on | output | 1 | Watchdog is enabled |
| wdt_reset_req | output | 1 | One-cycle reset request on overflow while running |
| wdt_wake_req | output | 1 | One-cycle wake request on overflow while sleeping |
| pdf_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Time-out status flag |

## Verification
The bench builds the block with CNT_W = 4, so one period is 16 prescaler outputs. This keeps even the 1:128 setting at 2048 ticks, which lets every prescaler ratio, two back-to-back overflows, the divide-by-4 source and the sleep freeze each be timed to the exact cycle. The default 8-bit counter would put the longest period near 33k ticks. With the shorter counter, tests that depend on the counter wrapping repeatedly fit easily.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

  localparam int WDT_KEY_W  = 4;
  localparam int WDT_SEL_W  = 3;
  localparam int WDT_PRE_W  = (1 << WDT_SEL_W) - 1;
  localparam logic [WDT_KEY_W-1:0] WDT_KEY_OFF = 4'b1010;
  localparam logic [WDT_SEL_W-1:0] WDT_SEL_RST = '1;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'b00,
    SRC_DIV4 = 2'b01,
    SRC_RC   = 2'b10,
    SRC_RC_B = 2'b11
  } wdt_src_e;

  // Enable decode: off only for the off key with no configuration force.
  function automatic logic wdt_enabled(input logic [WDT_KEY_W-1:0] key,
                                       input logic force_on);
    return force_on || (key != WDT_KEY_OFF);
  endfunction

  // Low-bit mask for a prescaler ratio of 2^sel.
  function automatic logic [WDT_PRE_W-1:0] pre_mask(input logic [WDT_SEL_W-1:0] sel);
    return WDT_PRE_W'((32'd1 << sel) - 32'd1);
  endfunction

endpackage

// File: rtl/wdt_keyed_ctl.sv
module wdt_keyed_ctl
  import wdt_keyed_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wdt_force,
  input  logic                 key_we,
  input  logic [WDT_KEY_W-1:0] key_wdata,
  input  logic                 div_we,
  input  logic [WDT_SEL_W-1:0] div_wdata,
  output logic                 wdt_on,
  output logic [WDT_PRE_W-1:0] mask
);

  logic [WDT_KEY_W-1:0] key_q;
  logic [WDT_SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= WDT_KEY_OFF;
      sel_q <= WDT_SEL_RST;
    end else begin
      if (key_we) key_q <= key_wdata;
      if (div_we) sel_q <= div_wdata;
    end
  end

  assign wdt_on = wdt_enabled(key_q, cfg_wdt_force);
  assign mask   = pre_mask(sel_q);

  // R2: a non-off key write leaves the block enabled on the next cycle
  a_r2_key_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_wdata != WDT_KEY_OFF) |=> wdt_on);

endmodule

// File: rtl/wdt_keyed_src.sv
module wdt_keyed_src
  import wdt_keyed_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_on,
  input  logic       clr_eff,
  input  logic       sleeping,
  input  logic [1:0] cfg_src,
  input  logic       xtal_tick,
  input  logic       rc_tick,
  output logic       adv
);

  logic [1:0] div_q;
  logic       div_tick;
  logic       src_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (!wdt_on || clr_eff) div_q <= '0;
    else if (!sleeping)        div_q <= div_q + 2'd1;
  end

  assign div_tick = (div_q == 2'd3) && !sleeping;

  always_comb begin
    unique case (wdt_src_e'(cfg_src))
      SRC_XTAL: src_tick = xtal_tick;
      SRC_DIV4: src_tick = div_tick;
      default:  src_tick = rc_tick;
    endcase
  end

  assign adv = wdt_on && src_tick;

  // R5: the divided system clock is frozen during sleep
  a_r5_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && wdt_on && !clr_eff) |=> (div_q == $past(div_q)));

endmodule

// File: rtl/wdt_keyed_chain.sv
module wdt_keyed_chain
  import wdt_keyed_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wdt_on,
  input  logic                 clr_eff,
  input  logic                 adv,
  input  logic                 sleeping,
  input  logic [WDT_PRE_W-1:0] mask,
  output logic                 ovf,
  output logic                 reset_req,
  output logic                 wake_req
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WDT_PRE_W-1:0] pre_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 pre_hit;

  assign pre_hit = adv && ((pre_q & mask) == mask);
  assign ovf     = pre_hit && (cnt_q == CNT_MAX) && !clr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!wdt_on || clr_eff) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (adv) begin
      pre_q <= pre_hit ? '0 : pre_q + 1'b1;
      if (pre_hit) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_req <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      reset_req <= ovf && !sleeping;
      wake_req  <= ovf && sleeping;
    end
  end

  // R12: disabled watchdog holds its count at zero
  a_r12_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_on |=> (cnt_q == '0 && pre_q == '0));

  // R11: each request lasts exactly one cycle
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || wake_req) |=> !(reset_req || wake_req));

  // R10: an effective clear restarts the chain
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_eff |=> (cnt_q == '0 && pre_q == '0));

endmodule

// File: rtl/wdt_keyed_flags.sv
module wdt_keyed_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_eff,
  input  logic halt,
  input  logic ovf,
  output logic pdf_flag,
  output logic to_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdf_flag <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      if (halt)         pdf_flag <= 1'b1;
      else if (clr_eff) pdf_flag <= 1'b0;
      if (ovf)          to_flag  <= 1'b1;
      else if (clr_eff) to_flag  <= 1'b0;
    end
  end

  // R6: halt always leaves the power-down flag set
  a_r6_halt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> pdf_flag);

  // R7: overflow sets the time-out flag
  a_r7_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> to_flag);

  // R8: overflow alone does not disturb the power-down flag
  a_r8_pdf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !halt && !clr_eff) |=> (pdf_flag == $past(pdf_flag)));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wdt_force,
  input  logic [1:0] cfg_src,
  input  logic       xtal_tick,
  input  logic       rc_tick,
  input  logic       sleeping,
  input  logic       key_we,
  input  logic [3:0] key_wdata,
  input  logic       div_we,
  input  logic [2:0] div_wdata,
  input  logic       clr_wdt,
  input  logic       halt,
  output logic       wdt_on,
  output logic       wdt_reset_req,
  output logic       wdt_wake_req,
  output logic       pdf_flag,
  output logic       to_flag
);

  logic [WDT_PRE_W-1:0] mask;
  logic                 clr_eff;
  logic                 adv;
  logic                 ovf;

  // clear-watchdog is a no-op while the watchdog is off
  assign clr_eff = clr_wdt && wdt_on;

  wdt_keyed_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wdt_force(cfg_wdt_force),
    .key_we(key_we), .key_wdata(key_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .wdt_on(wdt_on), .mask(mask)
  );

  wdt_keyed_src u_src (
    .clk(clk), .rst_n(rst_n), .wdt_on(wdt_on), .clr_eff(clr_eff),
    .sleeping(sleeping), .cfg_src(cfg_src),
    .xtal_tick(xtal_tick), .rc_tick(rc_tick), .adv(adv)
  );

  wdt_keyed_chain #(.CNT_W(CNT_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .wdt_on(wdt_on), .clr_eff(clr_eff),
    .adv(adv), .sleeping(sleeping), .mask(mask), .ovf(ovf),
    .reset_req(wdt_reset_req), .wake_req(wdt_wake_req)
  );

  wdt_keyed_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr_eff(clr_eff), .halt(halt), .ovf(ovf),
    .pdf_flag(pdf_flag), .to_flag(to_flag)
  );

  // R8: reset and wake requests never coincide
  a_r8_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_reset_req && wdt_wake_req));

  // R9: clear while off leaves the time-out flag alone
  a_r9_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt && !wdt_on && !ovf) |=> (to_flag == $past(to_flag)));

endmodule

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;

  localparam int CNT_W = 4;
  localparam int NPER  = 1 << CNT_W;

  logic clk = 0, rst_n = 0;
  logic cfg_wdt_force = 0;
  logic [1:0] cfg_src = 2'b00;
  logic xtal_tick = 0, rc_tick = 0, sleeping = 0;
  logic key_we = 0, div_we = 0, clr_wdt = 0, halt = 0;
  logic [3:0] key_wdata = 0;
  logic [2:0] div_wdata = 0;
  logic wdt_on, wdt_reset_req, wdt_wake_req, pdf_flag, to_flag;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  wdt_keyed #(.CNT_W(CNT_W)) uut (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr_key(input logic [3:0] v);
    @(negedge clk); key_we = 1; key_wdata = v;
    @(posedge clk); #1; key_we = 0;
  endtask

  task automatic wr_sel(input logic [2:0] v);
    @(negedge clk); div_we = 1; div_wdata = v;
    @(posedge clk); #1; div_we = 0;
  endtask

  task automatic strobe(input bit c, input bit h);
    @(negedge clk); clr_wdt = c; halt = h;
    @(posedge clk); #1; clr_wdt = 0; halt = 0;
  endtask

  // Request expected after exactly n edges counted from the last strobe edge.
  task automatic run_to(input string req, input int n, input bit wake);
    repeat (n - 1) @(posedge clk);
    #1;
    check(req, "no early request", {wdt_reset_req, wdt_wake_req}, 0);
    @(posedge clk); #1;
    check(req, "reset request", wdt_reset_req, !wake);
    check(req, "wake request", wdt_wake_req, wake);
  endtask

  task automatic quiet(input string req, input int n);
    int seen = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (wdt_reset_req || wdt_wake_req) seen++;
    end
    check(req, "requests while quiet", seen, 0);
  endtask

  task automatic t_reset();
    check("R1", "wdt_on after reset", wdt_on, 0);
    check("R1", "pdf after reset", pdf_flag, 0);
    check("R1", "to after reset", to_flag, 0);
    check("R1", "requests after reset", {wdt_reset_req, wdt_wake_req}, 0);
  endtask

  task automatic t_enable();
    @(negedge clk); cfg_wdt_force = 1; #1;
    check("R2", "force on", wdt_on, 1);
    @(negedge clk); cfg_wdt_force = 0; #1;
    check("R1", "off key, no force", wdt_on, 0);
    wr_key(4'b0101); check("R2", "key 0101", wdt_on, 1);
    wr_key(4'b1010); check("R1", "key 1010", wdt_on, 0);
    wr_key(4'b0000); check("R2", "key 0000", wdt_on, 1);
    @(negedge clk); cfg_wdt_force = 1; #1;
    check("R2", "force with key 0000", wdt_on, 1);
    @(negedge clk); cfg_wdt_force = 0;
    wr_key(4'b1010); check("R1", "back off", wdt_on, 0);
  endtask

  task automatic t_off_hold();
    wr_sel(3'd0);
    @(negedge clk); xtal_tick = 1;
    quiet("R12", 300);
    check("R12", "to stays clear while off", to_flag, 0);
    wr_key(4'b0101);
    run_to("R12", NPER, 0);
    check("R7", "to set by overflow", to_flag, 1);
  endtask

  task automatic t_ratio();
    foreach (sel_list[i]) begin
      wr_sel(sel_list[i]);
      strobe(1, 0);
      run_to("R3", NPER << sel_list[i], 0);
    end
  endtask
  logic [2:0] sel_list [3] = '{3'd0, 3'd3, 3'd7};

  task automatic t_restart();
    wr_sel(3'd0);
    strobe(1, 0);
    run_to("R10", NPER, 0);
    @(posedge clk); #1;
    check("R11", "single-cycle request", {wdt_reset_req, wdt_wake_req}, 0);
    run_to("R11", NPER - 1, 0);
  endtask

  task automatic t_flags();
    strobe(0, 1); check("R6", "halt sets pdf", pdf_flag, 1);
    strobe(1, 0);
    check("R6", "clear resets pdf", pdf_flag, 0);
    check("R7", "clear resets to", to_flag, 0);
    strobe(1, 1);
    check("R6", "halt beats clear", pdf_flag, 1);
    check("R7", "to clear with both", to_flag, 0);
  endtask

  task automatic t_sleep_wake();
    @(negedge clk); sleeping = 1; clr_wdt = 1; halt = 1;
    @(posedge clk); #1; clr_wdt = 0; halt = 0;
    run_to("R8", NPER, 1);
    check("R8", "pdf kept after wake", pdf_flag, 1);
    check("R8", "to set by sleep overflow", to_flag, 1);
    @(negedge clk); sleeping = 0;
  endtask

  task automatic t_sources();
    @(negedge clk); cfg_src = 2'b01; xtal_tick = 0; rc_tick = 0;
    strobe(1, 0);
    run_to("R4", 4 * NPER, 0);
    @(negedge clk); sleeping = 1; clr_wdt = 1;
    @(posedge clk); #1; clr_wdt = 0;
    quiet("R5", 300);
    @(negedge clk); sleeping = 0; cfg_src = 2'b10; rc_tick = 1;
    strobe(1, 0);
    run_to("R4", NPER, 0);
    @(negedge clk); rc_tick = 0; xtal_tick = 1;
    strobe(1, 0);
    quiet("R4", 2 * NPER);
    @(negedge clk); cfg_src = 2'b11; rc_tick = 1; xtal_tick = 0;
    strobe(1, 0);
    run_to("R4", NPER, 0);
  endtask

  task automatic t_clear_off();
    strobe(0, 1);
    wr_key(4'b1010);
    check("R9", "off before clear", wdt_on, 0);
    check("R9", "to before clear", to_flag, 1);
    strobe(1, 0);
    check("R9", "pdf kept on off-clear", pdf_flag, 1);
    check("R9", "to kept on off-clear", to_flag, 1);
    quiet("R12", 200);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_enable();
    t_off_hold();
    t_ratio();
    t_restart();
    t_flags();
    t_sleep_wake();
    t_sources();
    t_clear_off();
    finish_run();
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule